// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block is the command interpreter of a parallel NOR flash device. Each host write bus cycle reaches it as a one-clock strobe with its address and data. From these writes it recognises the unlock-prefixed command sequences and the single-write commands. It then issues program, chip-erase, sector-erase, suspend and resume requests to the array engine outside the block. It also tracks which view the device presents on reads: array data, identifier codes, the CFI query table, or the secured sector.

The array engine reports a running program or erase on the `busy` input. While `busy` is high the sequencer ignores writes, with one exception: a suspend request for an outstanding sector erase. The `byteMode` input selects the address pattern of the unlock cycles. It also selects how read offsets are scaled in identifier mode. Identifier data is decoded from `rdAddr` combinationally. Mode changes and operation requests appear on the clock edge that samples the write strobe.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset `mode` is 0 (array read), `opValid` is 0 and `idData` is 0. The mode codes are: 0 read, 1 identifier, 2 CFI, 3 secured sector, 4 erase suspended. A write sampled at a clock edge updates `mode` and the `op*` outputs at that same edge, and `opValid` lasts one cycle per request.
- R2: Every prefixed command begins with AAh followed by 55h. In word mode (`byteMode`=0) these go to 555h and 2AAh. In byte mode they go to AAAh and 555h. The third write goes to the first unlock address. Only the low 12 address bits are compared.
- R3: Unlock, then A0h, then one more write at any address issues `opKind`=1 (program). `opAddr` and `opData` are taken from that fourth write. The data may be any value, including F0h.
- R4: Unlock, then 80h, then a second unlock pair, then 10h at the first unlock address issues `opKind`=2 (chip erase).
- R5: The same prefix followed by 30h at any address issues `opKind`=3 (sector erase). `opSector` is address bits [21:12] in word mode and bits [22:13] in byte mode.
- R6: A write of F0h returns the device to mode 0 and clears any partial sequence. This holds at any step except the program-data step.
- R7: A write that does not match the address or data expected at the current step ends the sequence in mode 0 and issues nothing.
- R8: Unlock then 90h enters mode 1, unless the device is in mode 3. In mode 1, `idData` is decoded from the word offset. In word mode that offset is `rdAddr`[9:0]; in byte mode it is `rdAddr`[10:1], and only the low byte is returned. Offset 000h gives 007Fh, offset 100h gives 001Ch, offset 001h gives 22C9h (top boot) or 22CBh (bottom boot), and offset 002h gives `sectProt`. All other offsets, and all other modes, give 0.
- R9: From an idle sequence, a single write of 98h at 055h (word mode) or 0AAh (byte mode) enters mode 2.
- R10: Unlock then 88h enters mode 3. In mode 3, unlock then 90h then 00h at any address returns to mode 0.
- R11: While `busy` is 1, every write except a valid suspend is ignored. Mode and sequence state are left unchanged.
- R12: B0h written at any address while `busy` is 1 and a sector erase is outstanding issues `opKind`=4 and enters mode 4. With no sector erase outstanding, the write is ignored.
- R13: In mode 4, 30h at any address issues `opKind`=5 (resume) and returns to mode 0. All other writes are ignored. A sector erase stays outstanding until `busy` falls outside mode 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteMode | input | 1 | 1 selects byte addressing, 0 word addressing |
| busy | input | 1 | Array engine running a program or erase |
| sectProt | input | 1 | Protection status of the sector being queried |
| wrStb | input | 1 | One-cycle strobe for a host write bus cycle |
| wrAddr | input | 23 | Write address |
| wrData | input | 16 | Write data; commands use bits [7:0] |
| rdAddr | input | 11 | Low read-address bits used for identifier decode |
| mode | output | 3 | Current device mode code |
| opValid | output | 1 | One-cycle request to the array engine |
| opKind | output | 3 | Request kind: 1 program, 2 chip erase, 3 sector erase, 4 suspend, 5 resume |
| opAddr | output | 23 | Address of the write that issued the request |
| opData | output | 16 | Data of the write that issued the request |
| opSector | output | 10 | Sector index for a sector erase |
| idData | output | 16 | Identifier read data |

## Verification
The bench builds the default parameters: a 10-bit sector field starting at word-address bit 12, a 16-bit data bus and the top-boot identifier. These settings put the two sector-field positions within reach. The word-mode bits [21:12] and the byte-mode bits [22:13] are both exercised with matching addresses, as is the 22C9h device code. Both unlock patterns are driven, together with the busy and suspend interplay around an outstanding sector erase.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

  typedef enum logic [2:0] {
    MODE_READ   = 3'd0,
    MODE_ID     = 3'd1,
    MODE_CFI    = 3'd2,
    MODE_SECURE = 3'd3,
    MODE_SUSP   = 3'd4
  } devMode_e;

  typedef enum logic [2:0] {
    OP_NONE       = 3'd0,
    OP_PROG       = 3'd1,
    OP_CHIP_ERASE = 3'd2,
    OP_SECT_ERASE = 3'd3,
    OP_SUSPEND    = 3'd4,
    OP_RESUME     = 3'd5
  } opKind_e;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_UNL1,
    SEQ_UNL2,
    SEQ_PROG,
    SEQ_ERS1,
    SEQ_ERS2,
    SEQ_ERS3,
    SEQ_EXIT
  } seqStep_e;

  typedef struct packed {
    logic    issue;
    opKind_e kind;
  } ctrlStrobe_t;

  localparam logic [7:0] CMD_UNLOCK_A = 8'hAA;
  localparam logic [7:0] CMD_UNLOCK_B = 8'h55;
  localparam logic [7:0] CMD_RESET    = 8'hF0;
  localparam logic [7:0] CMD_PROG     = 8'hA0;
  localparam logic [7:0] CMD_ERASE    = 8'h80;
  localparam logic [7:0] CMD_CHIP     = 8'h10;
  localparam logic [7:0] CMD_SECTOR   = 8'h30;
  localparam logic [7:0] CMD_IDENT    = 8'h90;
  localparam logic [7:0] CMD_SECURE   = 8'h88;
  localparam logic [7:0] CMD_CFI      = 8'h98;
  localparam logic [7:0] CMD_SUSPEND  = 8'hB0;
  localparam logic [7:0] CMD_RESUME   = 8'h30;
  localparam logic [7:0] CMD_EXIT     = 8'h00;

endpackage

// File: rtl/nor_cmd_ctrl.sv
module nor_cmd_ctrl
  import nor_cmd_pkg::*;
#(
  parameter int UNL_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             byteMode,
  input  logic             busy,
  input  logic             wrStb,
  input  logic [UNL_W-1:0] wrAddrLo,
  input  logic [7:0]       cmd,
  output devMode_e         modeQ,
  output ctrlStrobe_t      strobe
);

  localparam logic [UNL_W-1:0] WORD_UNL_A = UNL_W'(12'h555);
  localparam logic [UNL_W-1:0] WORD_UNL_B = UNL_W'(12'h2AA);
  localparam logic [UNL_W-1:0] BYTE_UNL_A = UNL_W'(12'hAAA);
  localparam logic [UNL_W-1:0] BYTE_UNL_B = UNL_W'(12'h555);
  localparam logic [UNL_W-1:0] WORD_CFI   = UNL_W'(12'h055);
  localparam logic [UNL_W-1:0] BYTE_CFI   = UNL_W'(12'h0AA);

  seqStep_e seqQ, seqN;
  devMode_e modeN;
  logic     sectErasing, erasingN;
  logic     busyQ;
  logic     abort;
  logic     atUnlA, atUnlB, atCfi;

  assign atUnlA = wrAddrLo == (byteMode ? BYTE_UNL_A : WORD_UNL_A);
  assign atUnlB = wrAddrLo == (byteMode ? BYTE_UNL_B : WORD_UNL_B);
  assign atCfi  = wrAddrLo == (byteMode ? BYTE_CFI : WORD_CFI);

  always_comb begin
    seqN         = seqQ;
    modeN        = modeQ;
    erasingN     = sectErasing;
    strobe.issue = 1'b0;
    strobe.kind  = OP_NONE;
    abort        = 1'b0;
    if (busyQ && !busy && modeQ != MODE_SUSP) erasingN = 1'b0;
    if (wrStb) begin
      if (busy) begin
        if (cmd == CMD_SUSPEND && sectErasing && modeQ != MODE_SUSP) begin
          modeN        = MODE_SUSP;
          seqN         = SEQ_IDLE;
          strobe.issue = 1'b1;
          strobe.kind  = OP_SUSPEND;
        end
      end else if (modeQ == MODE_SUSP) begin
        if (cmd == CMD_RESUME) begin
          modeN        = MODE_READ;
          strobe.issue = 1'b1;
          strobe.kind  = OP_RESUME;
        end
      end else if (cmd == CMD_RESET && seqQ != SEQ_PROG) begin
        seqN  = SEQ_IDLE;
        modeN = MODE_READ;
      end else begin
        seqN  = SEQ_IDLE;
        abort = 1'b1;
        unique case (seqQ)
          SEQ_IDLE: begin
            if (cmd == CMD_UNLOCK_A && atUnlA) begin
              seqN = SEQ_UNL1; abort = 1'b0;
            end else if (cmd == CMD_CFI && atCfi) begin
              modeN = MODE_CFI; abort = 1'b0;
            end
          end
          SEQ_UNL1: if (cmd == CMD_UNLOCK_B && atUnlB) begin
            seqN = SEQ_UNL2; abort = 1'b0;
          end
          SEQ_UNL2: if (atUnlA) begin
            abort = 1'b0;
            case (cmd)
              CMD_PROG:   seqN = SEQ_PROG;
              CMD_ERASE:  seqN = SEQ_ERS1;
              CMD_SECURE: modeN = MODE_SECURE;
              CMD_IDENT:  if (modeQ == MODE_SECURE) seqN = SEQ_EXIT;
                          else modeN = MODE_ID;
              default:    abort = 1'b1;
            endcase
          end
          SEQ_PROG: begin
            abort        = 1'b0;
            strobe.issue = 1'b1;
            strobe.kind  = OP_PROG;
          end
          SEQ_ERS1: if (cmd == CMD_UNLOCK_A && atUnlA) begin
            seqN = SEQ_ERS2; abort = 1'b0;
          end
          SEQ_ERS2: if (cmd == CMD_UNLOCK_B && atUnlB) begin
            seqN = SEQ_ERS3; abort = 1'b0;
          end
          SEQ_ERS3: begin
            if (cmd == CMD_CHIP && atUnlA) begin
              abort        = 1'b0;
              strobe.issue = 1'b1;
              strobe.kind  = OP_CHIP_ERASE;
            end else if (cmd == CMD_SECTOR) begin
              abort        = 1'b0;
              erasingN     = 1'b1;
              strobe.issue = 1'b1;
              strobe.kind  = OP_SECT_ERASE;
            end
          end
          SEQ_EXIT: if (cmd == CMD_EXIT) begin
            modeN = MODE_READ; abort = 1'b0;
          end
          default: abort = 1'b1;
        endcase
        if (abort) modeN = MODE_READ;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seqQ        <= SEQ_IDLE;
      modeQ       <= MODE_READ;
      sectErasing <= 1'b0;
      busyQ       <= 1'b0;
    end else begin
      seqQ        <= seqN;
      modeQ       <= modeN;
      sectErasing <= erasingN;
      busyQ       <= busy;
    end
  end

  // R6: reset command lands in read mode with an empty sequence
  assert_reset_cmd_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb && !busy && modeQ != MODE_SUSP && cmd == CMD_RESET && seqQ != SEQ_PROG)
    |=> (modeQ == MODE_READ && seqQ == SEQ_IDLE));

  // R11: writes during busy other than B0h leave state alone
  assert_busy_ignore_R11: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb && busy && cmd != CMD_SUSPEND) |=> ($stable(modeQ) && $stable(seqQ)));

  // R12: suspended mode always has an erase behind it
  assert_susp_has_erase_R12: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_SUSP) |-> sectErasing);

  // R12: suspend is only entered from a busy cycle
  assert_susp_from_busy_R12: assert property (@(posedge clk) disable iff (!rstN)
    $rose(modeQ == MODE_SUSP) |-> $past(busy));

endmodule

// File: rtl/nor_cmd_dp.sv
module nor_cmd_dp
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W   = 23,
  parameter int DATA_W   = 16,
  parameter int SECT_W   = 10,
  parameter int SECT_LSB = 12,
  parameter int ID_W     = 11,
  parameter bit TOP_BOOT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteMode,
  input  logic              sectProt,
  input  logic              wrStb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ID_W-1:0]   rdAddr,
  input  devMode_e          modeQ,
  input  ctrlStrobe_t       strobe,
  output logic              opValid,
  output opKind_e           opKind,
  output logic [ADDR_W-1:0] opAddr,
  output logic [DATA_W-1:0] opData,
  output logic [SECT_W-1:0] opSector,
  output logic [15:0]       idData
);

  localparam logic [15:0] MFR_CODE  = 16'h007F;
  localparam logic [15:0] BANK_CODE = 16'h001C;
  localparam int          OFS_W     = ID_W - 1;

  logic [15:0]       devCode;
  logic [SECT_W-1:0] sectWord, sectByte;
  logic [OFS_W-1:0]  ofs;
  logic [15:0]       idRaw;

  generate
    if (TOP_BOOT) begin : g_top
      assign devCode = 16'h22C9;
    end else begin : g_bottom
      assign devCode = 16'h22CB;
    end
  endgenerate

  assign sectWord = wrAddr[SECT_LSB+SECT_W-1:SECT_LSB];
  assign sectByte = wrAddr[SECT_LSB+SECT_W:SECT_LSB+1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opValid  <= 1'b0;
      opKind   <= OP_NONE;
      opAddr   <= '0;
      opData   <= '0;
      opSector <= '0;
    end else begin
      opValid <= strobe.issue;
      if (strobe.issue) begin
        opKind   <= strobe.kind;
        opAddr   <= wrAddr;
        opData   <= wrData;
        opSector <= byteMode ? sectByte : sectWord;
      end
    end
  end

  assign ofs = byteMode ? rdAddr[ID_W-1:1] : rdAddr[OFS_W-1:0];

  always_comb begin
    unique case (ofs)
      OFS_W'(10'h000): idRaw = MFR_CODE;
      OFS_W'(10'h100): idRaw = BANK_CODE;
      OFS_W'(10'h001): idRaw = devCode;
      OFS_W'(10'h002): idRaw = {15'd0, sectProt};
      default:         idRaw = 16'h0000;
    endcase
    if (modeQ != MODE_ID) idData = 16'h0000;
    else if (byteMode)    idData = idRaw & 16'h00FF;
    else                  idData = idRaw;
  end

  // R3: every request comes from a sampled write
  assert_req_from_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    opValid |-> $past(wrStb));

  // R5: a sector erase request is always triggered by 30h
  assert_sector_cmd_R5: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opKind == OP_SECT_ERASE) |-> ($past(wrData[7:0]) == 8'h30));

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_cmd_pkg::*;
#(
  parameter int SECT_W   = 10,
  parameter int SECT_LSB = 12,
  parameter int DATA_W   = 16,
  parameter bit TOP_BOOT = 1'b1,
  localparam int ADDR_W  = SECT_LSB + SECT_W + 1,
  localparam int UNL_W   = 12,
  localparam int ID_W    = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteMode,
  input  logic              busy,
  input  logic              sectProt,
  input  logic              wrStb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ID_W-1:0]   rdAddr,
  output logic [2:0]        mode,
  output logic              opValid,
  output logic [2:0]        opKind,
  output logic [ADDR_W-1:0] opAddr,
  output logic [DATA_W-1:0] opData,
  output logic [SECT_W-1:0] opSector,
  output logic [15:0]       idData
);

  devMode_e    modeQ;
  ctrlStrobe_t strobe;
  opKind_e     kindQ;

  nor_cmd_ctrl #(.UNL_W(UNL_W)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .byteMode (byteMode),
    .busy     (busy),
    .wrStb    (wrStb),
    .wrAddrLo (wrAddr[UNL_W-1:0]),
    .cmd      (wrData[7:0]),
    .modeQ    (modeQ),
    .strobe   (strobe)
  );

  nor_cmd_dp #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .SECT_W   (SECT_W),
    .SECT_LSB (SECT_LSB),
    .ID_W     (ID_W),
    .TOP_BOOT (TOP_BOOT)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .byteMode (byteMode),
    .sectProt (sectProt),
    .wrStb    (wrStb),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .rdAddr   (rdAddr),
    .modeQ    (modeQ),
    .strobe   (strobe),
    .opValid  (opValid),
    .opKind   (kindQ),
    .opAddr   (opAddr),
    .opData   (opData),
    .opSector (opSector),
    .idData   (idData)
  );

  assign mode   = modeQ;
  assign opKind = kindQ;

endmodule

// File: tb/nor_cmd_seq_tb.sv
module nor_cmd_seq_tb_top;

  typedef struct packed {
    logic        bm;
    logic        bsy;
    logic [22:0] addr;
    logic [15:0] data;
    logic        expV;
    logic [2:0]  expK;
    logic [2:0]  expM;
  } vec_t;

  localparam int NV = 51;
  localparam vec_t VECS [0:NV-1] = '{
    // R3: program whose data is F0h
    '{1'b0,1'b0,23'h555,16'h00AA,1'b0,3'd0,3'd0},
    '{1'b0,1'b0,23'h2AA,16'h0055,1'b0,3'd0,3'd0},
    '{1'b0,1'b0,23'h555,16'h00A0,1'b0,3'd0,3'd0},
    '{1'b0,1'b0,23'h1234,16'h00F0,1'b1,3'd1,3'd0},
    // R8: identifier entry, R11: busy ignores F0h, R6: F0h exits
    '{1'b0,1'b0,23'h555,16'h00AA,1'b0,3'd0,3'd0},
    '{1'b0,1'b0,23'h2AA,16'h0055,1'b0,3'd0,3'd0},
    '{1'b0,1'b0,23'h555,16'h0090,1'b0,3'd0,3'd1},
    '{1'b0,1'b1,23'h000,16'h00F0,1'b0,3'd0,3'd1},
    '{1'b0,1'b0,23'h3C0,16'h00F0,1'b0,3'd0,3'd0},
    // R9: CFI word and byte
    '{1'b0,1'b0,23'h055,16'h0098,1'b0,3'd0,3'd2},
    '{1'b0,1'b0,23'h000,16'h00F0,1'b0,3'd0,3'd0},
    '{1'b1,1'b0,23'h0AA,16'h0098,1'b0,3'd0,3'd2},
    '{1'b1,1'b0,23'h000,16'h00F0,1'b0,3'd0,3'd0},
    // R2: byte-mode program
    '{1'b1,1'b0,23'hAAA,16'h00AA,1'b0,3'd0,3'd0},
    '{1'b1,1'b0,23'h555,16'h0055,1'b0,3'd0,3'd0},
    '{1'b1,1'b0,23'hAAA,16'h00A0,1'b0,3'd0,3'd0},
    '{1'b1,1'b0,23'h040,16'h003C,1'b1,3'd1,3'd0},
    // R2/R7: word unlock addresses in byte mode abort
    '{1'b1,1'b0,23'h555,16'h00AA,1'b0,3'd0,3'd0},
    '{1'b1,1'b0,23'h2AA,16'h0055,1'b0,3'd0,3'd0},
    '{1'b1,1'b0,23'hAAA,16'h00A0,1'b0,3'd0,3'd0},
    '{1'b1,1'b0,23'h123,16'h0077,1'b0,3'd0,3'd0},
    // R7: wrong second address
    '{1'b0,1'b0,23'h555,16'h00AA,1'b0,3'd0,3'd0},
    '{1'b0,1'b0,23'h2AB,16'h0055,1'b0,3'd0,3'd0},
    '{1'b0,1'b0,23'h555,16'h0090,1'b0,3'd0,3'd0},
    // R4: chip erase
    '{1'b0,1'b0,23'h555,16'h00AA,1'b0,3'd0,3'd0},
    '{1'b0,1'b0,23'h2AA,16'h0055,1'b0,3'd0,3'd0},
    '{1'b0,1'b0,23'h555,16'h0080,1'b0,3'd0,3'd0},
    '{1'b0,1'b0,23'h555,16'h00AA,1'b0,3'd0,3'd0},
    '{1'b0,1'b0,23'h2AA,16'h0055,1'b0,3'd0,3'd0},
    '{1'b0,1'b0,23'h555,16'h0010,1'b1,3'd2,3'd0},
    // R10: secured sector entry and exit
    '{1'b0,1'b0,23'h555,16'h00AA,1'b0,3'd0,3'd0},
    '{1'b0,1'b0,23'h2AA,16'h0055,1'b0,3'd0,3'd0},
    '{1'b0,1'b0,23'h555,16'h0088,1'b0,3'd0,3'd3},
    '{1'b0,1'b0,23'h555,16'h00AA,1'b0,3'd0,3'd3},
    '{1'b0,1'b0,23'h2AA,16'h0055,1'b0,3'd0,3'd3},
    '{1'b0,1'b0,23'h555,16'h0090,1'b0,3'd0,3'd3},
    '{1'b0,1'b0,23'h777,16'h0000,1'b0,3'd0,3'd0},
    // R6: F0h mid-sequence
    '{1'b0,1'b0,23'h555,16'h00AA,1'b0,3'd0,3'd0},
    '{1'b0,1'b0,23'h2AA,16'h0055,1'b0,3'd0,3'd0},
    '{1'b0,1'b0,23'h777,16'h00F0,1'b0,3'd0,3'd0},
    '{1'b0,1'b0,23'h555,16'h00A0,1'b0,3'd0,3'd0},
    // R7: stray write leaves identifier mode
    '{1'b0,1'b0,23'h555,16'h00AA,1'b0,3'd0,3'd0},
    '{1'b0,1'b0,23'h2AA,16'h0055,1'b0,3'd0,3'd0},
    '{1'b0,1'b0,23'h555,16'h0090,1'b0,3'd0,3'd1},
    '{1'b0,1'b0,23'h123,16'h0045,1'b0,3'd0,3'd0},
    // R7: erase aborted in second unlock
    '{1'b0,1'b0,23'h555,16'h00AA,1'b0,3'd0,3'd0},
    '{1'b0,1'b0,23'h2AA,16'h0055,1'b0,3'd0,3'd0},
    '{1'b0,1'b0,23'h555,16'h0080,1'b0,3'd0,3'd0},
    '{1'b0,1'b0,23'h555,16'h00AA,1'b0,3'd0,3'd0},
    '{1'b0,1'b0,23'h2AA,16'h0056,1'b0,3'd0,3'd0},
    '{1'b0,1'b0,23'h555,16'h0010,1'b0,3'd0,3'd0}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        byteMode = 1'b0;
  logic        busy = 1'b0;
  logic        sectProt = 1'b0;
  logic        wrStb = 1'b0;
  logic [22:0] wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [10:0] rdAddr = '0;
  logic [2:0]  mode;
  logic        opValid;
  logic [2:0]  opKind;
  logic [22:0] opAddr;
  logic [15:0] opData;
  logic [9:0]  opSector;
  logic [15:0] idData;

  int nChecks = 0;
  int nFail   = 0;

  always #4 clk = ~clk;

  nor_cmd_seq dut_i (
    .clk(clk), .rstN(rstN), .byteMode(byteMode), .busy(busy),
    .sectProt(sectProt), .wrStb(wrStb), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .mode(mode), .opValid(opValid), .opKind(opKind),
    .opAddr(opAddr), .opData(opData), .opSector(opSector), .idData(idData)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic bm, input logic bsy, input logic [22:0] a, input logic [15:0] d);
    @(negedge clk);
    byteMode = bm; busy = bsy; wrAddr = a; wrData = d; wrStb = 1'b1;
    @(negedge clk);
    wrStb = 1'b0;
  endtask

  task automatic unlock(input logic bm);
    wr(bm, 1'b0, bm ? 23'hAAA : 23'h555, 16'h00AA);
    wr(bm, 1'b0, bm ? 23'h555 : 23'h2AA, 16'h0055);
  endtask

  task automatic idRead(input string req, input logic [10:0] a, input logic [15:0] exp);
    rdAddr = a;
    #1;
    chk(req, {16'd0, idData}, {16'd0, exp});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 mode", {29'd0, mode}, 32'd0);
    chk("R1 opValid", {31'd0, opValid}, 32'd0);
    chk("R1 idData", {16'd0, idData}, 32'd0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      wr(VECS[i].bm, VECS[i].bsy, VECS[i].addr, VECS[i].data);
      chk($sformatf("R2-table[%0d] opValid", i), {31'd0, opValid}, {31'd0, VECS[i].expV});
      chk($sformatf("R7-table[%0d] mode", i), {29'd0, mode}, {29'd0, VECS[i].expM});
      if (VECS[i].expV)
        chk($sformatf("R3-table[%0d] opKind", i), {29'd0, opKind}, {29'd0, VECS[i].expK});
    end

    // R5: word-mode sector erase
    unlock(1'b0);
    wr(1'b0, 1'b0, 23'h555, 16'h0080);
    unlock(1'b0);
    wr(1'b0, 1'b0, 23'h2A5123, 16'h0030);
    chk("R5 opValid", {31'd0, opValid}, 32'd1);
    chk("R5 opKind", {29'd0, opKind}, 32'd3);
    chk("R5 opSector", {22'd0, opSector}, 32'h2A5);
    chk("R5 opAddr", {9'd0, opAddr}, 32'h2A5123);
    @(negedge clk);
    chk("R1 single pulse", {31'd0, opValid}, 32'd0);

    // R11: busy ignores a normal write
    wr(1'b0, 1'b1, 23'h555, 16'h00AA);
    chk("R11 opValid", {31'd0, opValid}, 32'd0);
    chk("R11 mode", {29'd0, mode}, 32'd0);
    // R12: suspend
    wr(1'b0, 1'b1, 23'h000, 16'h00B0);
    chk("R12 opValid", {31'd0, opValid}, 32'd1);
    chk("R12 opKind", {29'd0, opKind}, 32'd4);
    chk("R12 mode", {29'd0, mode}, 32'd4);
    // R13: suspended mode ignores others, then resumes
    wr(1'b0, 1'b0, 23'h2AA, 16'h0055);
    chk("R13 ignore opValid", {31'd0, opValid}, 32'd0);
    chk("R13 ignore mode", {29'd0, mode}, 32'd4);
    wr(1'b0, 1'b0, 23'h000, 16'h00F0);
    chk("R13 F0 ignored mode", {29'd0, mode}, 32'd4);
    wr(1'b0, 1'b0, 23'h3F0, 16'h0030);
    chk("R13 resume opValid", {31'd0, opValid}, 32'd1);
    chk("R13 resume opKind", {29'd0, opKind}, 32'd5);
    chk("R13 resume mode", {29'd0, mode}, 32'd0);
    // R13: erase finishes, later suspend ignored (R12)
    @(negedge clk); busy = 1'b1;
    @(negedge clk); busy = 1'b0;
    @(negedge clk);
    wr(1'b0, 1'b1, 23'h000, 16'h00B0);
    chk("R12 no erase opValid", {31'd0, opValid}, 32'd0);
    chk("R12 no erase mode", {29'd0, mode}, 32'd0);

    // R5: byte-mode sector field
    unlock(1'b1);
    wr(1'b1, 1'b0, 23'hAAA, 16'h0080);
    unlock(1'b1);
    wr(1'b1, 1'b0, 23'h54A246, 16'h0030);
    chk("R5 byte opKind", {29'd0, opKind}, 32'd3);
    chk("R5 byte opSector", {22'd0, opSector}, 32'h2A5);

    // R3: program address and data capture
    unlock(1'b0);
    wr(1'b0, 1'b0, 23'h555, 16'h00A0);
    wr(1'b0, 1'b0, 23'h3FFF80, 16'h5A5A);
    chk("R3 opKind", {29'd0, opKind}, 32'd1);
    chk("R3 opAddr", {9'd0, opAddr}, 32'h3FFF80);
    chk("R3 opData", {16'd0, opData}, 32'h5A5A);

    // R8: identifier reads
    unlock(1'b0);
    wr(1'b0, 1'b0, 23'h555, 16'h0090);
    idRead("R8 mfr", 11'h000, 16'h007F);
    idRead("R8 bank", 11'h100, 16'h001C);
    idRead("R8 device", 11'h001, 16'h22C9);
    sectProt = 1'b1;
    idRead("R8 prot", 11'h002, 16'h0001);
    sectProt = 1'b0;
    idRead("R8 unprot", 11'h002, 16'h0000);
    idRead("R8 other", 11'h003, 16'h0000);
    @(negedge clk); byteMode = 1'b1;
    idRead("R8 byte bank", 11'h200, 16'h001C);
    idRead("R8 byte device", 11'h002, 16'h00C9);
    idRead("R8 byte mfr", 11'h000, 16'h007F);
    wr(1'b0, 1'b0, 23'h000, 16'h00F0);
    idRead("R8 read mode", 11'h000, 16'h0000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule